// File: doc/BRIEF.md
# Oldest-First Reservation Node Table

This block is the waiting area in front of one class of function unit in an out-of-order core. Decoded operations arrive one per cycle on a merge port. Each operation carries an opcode, a destination tag and two source operands. A source either holds its value already, as a literal or a ready operand, or waits on the tag of the producer that will compute it. Storage is a circular buffer, so entries stay in arrival order. The merge port reports the position it assigns to each new entry, and that position is used later as a checkpoint.

Several result broadcast ports carry tag and value pairs, and all of them are compared in parallel against every waiting source. A source whose tag matches captures the value and becomes ready. Each cycle the oldest entry whose two sources are ready is offered on the single issue port. When a branch is mispredicted, a repair request names the checkpoint position of the youngest entry to keep. Every entry merged after it is dropped, and merging resumes at the slot that follows it.

Top module: `ntab_oldest`

## Requirements
- R1: Out of reset the table is empty, `mrg_rdy` is 1, `iss_vld` is 0 and `mrg_pos` is 0.
- R2: A merge is taken when `mrg_vld` and `mrg_rdy` are high and `rep_req` is low. `mrg_pos`, made of a lap bit above the slot index, shows the position given to the entry taken in that cycle, and it advances by one, modulo twice the depth, for each entry taken.
- R3: `mrg_rdy` is low while DEPTH slots are occupied. A slot stays occupied until it has issued and every older slot has been released. At most one slot, the oldest, is released per cycle, in the cycle after it is both the oldest occupied slot and issued.
- R4: `iss_vld` is high exactly when some held entry has both sources ready and no repair is requested. The entry offered is the oldest such entry.
- R5: An offered entry leaves the table only in a cycle where `iss_rdy` is high. Otherwise it stays and remains eligible.
- R6: A broadcast on any port whose valid bit is set and whose tag equals a waiting source's tag stores the value and marks that source ready. The entry can issue from the next cycle on.
- R7: A broadcast in the same cycle as a merge is compared against the incoming entry's waiting sources, so that wakeup is not lost.
- R8: A source merged with its ready bit set keeps its merged value, and a later broadcast that matches its tag field has no effect on it.
- R9: A repair whose position belongs to a held entry keeps that entry and every older one, drops all younger ones, and sets `mrg_pos` to that position plus one.
- R10: A repair whose position is not that of a held entry drops every entry.
- R11: In a repair cycle `iss_vld` is 0 and any merge offered is discarded.
- R12: When several ports match the same waiting source in one cycle, the value on the lowest-numbered port is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrg_vld | input | 1 | New entry offered |
| mrg_rdy | output | 1 | Table has a free slot |
| mrg_op | input | OP_W | Opcode of new entry |
| mrg_dst | input | TAG_W | Destination tag of new entry |
| mrg_a_rdy | input | 1 | Source A already holds its value |
| mrg_a_tag | input | TAG_W | Source A producer tag |
| mrg_a_val | input | DATA_W | Source A value or literal |
| mrg_b_rdy | input | 1 | Source B already holds its value |
| mrg_b_tag | input | TAG_W | Source B producer tag |
| mrg_b_val | input | DATA_W | Source B value or literal |
| mrg_pos | output | $clog2(DEPTH)+1 | Position assigned to the next merge |
| bc_vld | input | NB | Broadcast valid, one bit per port |
| bc_tag | input | NB*TAG_W | Broadcast tags, port p at bits p*TAG_W upward |
| bc_val | input | NB*DATA_W | Broadcast values, port p at bits p*DATA_W upward |
| iss_vld | output | 1 | An entry is offered to the function unit |
| iss_rdy | input | 1 | Function unit takes the offered entry |
| iss_op | output | OP_W | Opcode of offered entry |
| iss_dst | output | TAG_W | Destination tag of offered entry |
| iss_a | output | DATA_W | Source A value of offered entry |
| iss_b | output | DATA_W | Source B value of offered entry |
| rep_req | input | 1 | Repair request |
| rep_pos | input | $clog2(DEPTH)+1 | Position of youngest entry to keep |

## Verification
On every cycle the assertions check the pointer arithmetic of the merge port: the step on an accepted merge, the freeze while full, the bound on occupancy, the absence of issue during repair and on an empty table, and that an offered entry that was not taken is offered again. Which entry is chosen by age, which values the wakeups capture, the same-cycle merge and broadcast race, port priority on duplicate tags, literal immunity, and what a repair keeps all depend on the history of the table. Only the bench's reference model, run alongside directed and random traffic, can show them.

// File: rtl/ntab_pkg.sv
package ntab_pkg;
  localparam int NTAB_DEPTH  = 8;
  localparam int NTAB_TAG_W  = 6;
  localparam int NTAB_DATA_W = 16;
  localparam int NTAB_OP_W   = 4;
  localparam int NTAB_NB     = 2;
  localparam int NTAB_NSRC   = 2;
endpackage

// File: rtl/ntab_src_wake.sv
module ntab_src_wake #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int NB     = 2
) (
  input  logic                 cur_rdy,
  input  logic [TAG_W-1:0]     cur_tag,
  input  logic [DATA_W-1:0]    cur_val,
  input  logic [NB-1:0]        bc_vld,
  input  logic [NB*TAG_W-1:0]  bc_tag,
  input  logic [NB*DATA_W-1:0] bc_val,
  output logic                 nxt_rdy,
  output logic [DATA_W-1:0]    nxt_val
);
  logic [NB-1:0] hit;

  for (genvar p = 0; p < NB; p++) begin : g_cmp
    assign hit[p] = bc_vld[p] && (bc_tag[p*TAG_W +: TAG_W] == cur_tag);
  end

  // highest port first so the lowest matching port is the last writer
  always_comb begin
    nxt_rdy = cur_rdy;
    nxt_val = cur_val;
    if (!cur_rdy) begin
      for (int p = NB - 1; p >= 0; p--) begin
        if (hit[p]) begin
          nxt_rdy = 1'b1;
          nxt_val = bc_val[p*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/ntab_age_pick.sv
module ntab_age_pick #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic [DEPTH-1:0] req,
  input  logic [PTR_W-1:0] base,
  output logic             gnt_vld,
  output logic [PTR_W-1:0] gnt_idx
);
  logic [2*DEPTH-1:0] dbl;
  logic [DEPTH-1:0]   rot;
  logic [PTR_W-1:0]   off;

  assign dbl     = {req, req};
  assign rot     = dbl[base +: DEPTH];
  assign gnt_vld = |req;

  // lowest set bit of the rotated vector is the oldest request
  always_comb begin
    off = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (rot[k]) off = PTR_W'(k);
    end
  end

  assign gnt_idx = base + off;
endmodule

// File: rtl/ntab_oldest.sv
module ntab_oldest
  import ntab_pkg::*;
#(
  parameter int DEPTH  = NTAB_DEPTH,
  parameter int TAG_W  = NTAB_TAG_W,
  parameter int DATA_W = NTAB_DATA_W,
  parameter int OP_W   = NTAB_OP_W,
  parameter int NB     = NTAB_NB,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int POS_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mrg_vld,
  output logic                 mrg_rdy,
  input  logic [OP_W-1:0]      mrg_op,
  input  logic [TAG_W-1:0]     mrg_dst,
  input  logic                 mrg_a_rdy,
  input  logic [TAG_W-1:0]     mrg_a_tag,
  input  logic [DATA_W-1:0]    mrg_a_val,
  input  logic                 mrg_b_rdy,
  input  logic [TAG_W-1:0]     mrg_b_tag,
  input  logic [DATA_W-1:0]    mrg_b_val,
  output logic [POS_W-1:0]     mrg_pos,
  input  logic [NB-1:0]        bc_vld,
  input  logic [NB*TAG_W-1:0]  bc_tag,
  input  logic [NB*DATA_W-1:0] bc_val,
  output logic                 iss_vld,
  input  logic                 iss_rdy,
  output logic [OP_W-1:0]      iss_op,
  output logic [TAG_W-1:0]     iss_dst,
  output logic [DATA_W-1:0]    iss_a,
  output logic [DATA_W-1:0]    iss_b,
  input  logic                 rep_req,
  input  logic [POS_W-1:0]     rep_pos
);
  localparam int NSRC = NTAB_NSRC;

  // pointer state
  logic [POS_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [DEPTH-1:0] vld_q, vld_d;

  // entry storage
  logic [OP_W-1:0]   op_q   [DEPTH];
  logic [TAG_W-1:0]  dst_q  [DEPTH];
  logic              srdy_q [DEPTH][NSRC];
  logic              srdy_d [DEPTH][NSRC];
  logic [TAG_W-1:0]  stag_q [DEPTH][NSRC];
  logic [DATA_W-1:0] sval_q [DEPTH][NSRC];
  logic [DATA_W-1:0] sval_d [DEPTH][NSRC];
  logic [DEPTH-1:0]  ld;

  // wakeup results
  logic              w_rdy [DEPTH][NSRC];
  logic [DATA_W-1:0] w_val [DEPTH][NSRC];
  logic              m_in_rdy [NSRC];
  logic [TAG_W-1:0]  m_in_tag [NSRC];
  logic [DATA_W-1:0] m_in_val [NSRC];
  logic              m_rdy [NSRC];
  logic [DATA_W-1:0] m_val [NSRC];

  // control
  logic [POS_W-1:0] occ;
  logic             full;
  logic             mrg_fire;
  logic             iss_fire;
  logic [DEPTH-1:0] elig;
  logic             pick_vld;
  logic [PTR_W-1:0] pick_idx;
  logic [POS_W-1:0] rep_tail;
  logic [POS_W-1:0] rep_dist;
  logic             rep_in_win;
  logic [POS_W-1:0] keep_cnt;
  logic [PTR_W-1:0] tail_slot;
  logic [PTR_W-1:0] head_slot;

  assign m_in_rdy[0] = mrg_a_rdy;
  assign m_in_tag[0] = mrg_a_tag;
  assign m_in_val[0] = mrg_a_val;
  assign m_in_rdy[1] = mrg_b_rdy;
  assign m_in_tag[1] = mrg_b_tag;
  assign m_in_val[1] = mrg_b_val;

  assign head_slot = head_q[PTR_W-1:0];
  assign tail_slot = tail_q[PTR_W-1:0];
  assign occ       = tail_q - head_q;
  assign full      = (occ == POS_W'(DEPTH));
  assign mrg_rdy   = !full;
  assign mrg_pos   = tail_q;
  assign mrg_fire  = mrg_vld && !full && !rep_req;

  // wakeup for held sources
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    for (genvar j = 0; j < NSRC; j++) begin : g_src
      ntab_src_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NB(NB)) u_wake (
        .cur_rdy (srdy_q[i][j]),
        .cur_tag (stag_q[i][j]),
        .cur_val (sval_q[i][j]),
        .bc_vld  (bc_vld),
        .bc_tag  (bc_tag),
        .bc_val  (bc_val),
        .nxt_rdy (w_rdy[i][j]),
        .nxt_val (w_val[i][j])
      );
    end
    assign elig[i] = vld_q[i] && srdy_q[i][0] && srdy_q[i][1];
  end

  // wakeup for the entry being merged
  for (genvar j = 0; j < NSRC; j++) begin : g_msrc
    ntab_src_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NB(NB)) u_mwake (
      .cur_rdy (m_in_rdy[j]),
      .cur_tag (m_in_tag[j]),
      .cur_val (m_in_val[j]),
      .bc_vld  (bc_vld),
      .bc_tag  (bc_tag),
      .bc_val  (bc_val),
      .nxt_rdy (m_rdy[j]),
      .nxt_val (m_val[j])
    );
  end

  // oldest ready selection
  ntab_age_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pick (
    .req     (elig),
    .base    (head_slot),
    .gnt_vld (pick_vld),
    .gnt_idx (pick_idx)
  );

  assign iss_vld  = pick_vld && !rep_req;
  assign iss_fire = iss_vld && iss_rdy;
  assign iss_op   = op_q[pick_idx];
  assign iss_dst  = dst_q[pick_idx];
  assign iss_a    = sval_q[pick_idx][0];
  assign iss_b    = sval_q[pick_idx][1];

  // repair window
  assign rep_tail   = rep_pos + POS_W'(1);
  assign rep_dist   = rep_tail - head_q;
  assign rep_in_win = (rep_dist != '0) && (rep_dist <= occ);
  assign keep_cnt   = rep_in_win ? rep_dist : '0;

  // next state
  always_comb begin
    vld_d  = vld_q;
    tail_d = tail_q;
    head_d = head_q;
    ld     = '0;

    if (iss_fire) vld_d[pick_idx] = 1'b0;

    if (rep_req) begin
      tail_d = rep_in_win ? rep_tail : head_q;
      for (int i = 0; i < DEPTH; i++) begin
        if ({1'b0, PTR_W'(PTR_W'(i) - head_slot)} >= keep_cnt) vld_d[i] = 1'b0;
      end
    end else if (mrg_fire) begin
      ld[tail_slot]    = 1'b1;
      vld_d[tail_slot] = 1'b1;
      tail_d           = tail_q + POS_W'(1);
    end

    if ((head_q != tail_q) && !vld_q[head_slot] && (head_q != tail_d))
      head_d = head_q + POS_W'(1);

    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < NSRC; j++) begin
        srdy_d[i][j] = ld[i] ? m_rdy[j] : w_rdy[i][j];
        sval_d[i][j] = ld[i] ? m_val[j] : w_val[i][j];
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      vld_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < NSRC; j++) srdy_q[i][j] <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < NSRC; j++) srdy_q[i][j] <= srdy_d[i][j];
    end
  end

  // data registers, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < NSRC; j++) sval_q[i][j] <= sval_d[i][j];
      if (ld[i]) begin
        op_q[i]      <= mrg_op;
        dst_q[i]     <= mrg_dst;
        stag_q[i][0] <= mrg_a_tag;
        stag_q[i][1] <= mrg_b_tag;
      end
    end
  end
endmodule

// File: rtl/ntab_oldest_chk.sv
module ntab_oldest_chk #(
  parameter int DEPTH = 8,
  parameter int POS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrg_vld,
  input logic             mrg_rdy,
  input logic [POS_W-1:0] mrg_pos,
  input logic             iss_vld,
  input logic             iss_rdy,
  input logic             rep_req,
  input logic [POS_W-1:0] head_q,
  input logic [POS_W-1:0] tail_q
);
  assert_pos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mrg_vld && mrg_rdy && !rep_req) |=> (mrg_pos == POS_W'($past(mrg_pos) + POS_W'(1))));

  assert_full_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrg_rdy && !rep_req) |=> (mrg_pos == $past(mrg_pos)));

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (POS_W'(tail_q - head_q) <= POS_W'(DEPTH)));

  assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q == head_q) |-> !iss_vld);

  assert_offer_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !iss_rdy && !rep_req) |=> (iss_vld || rep_req));

  assert_no_issue_repair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rep_req |-> !iss_vld);
endmodule

bind ntab_oldest ntab_oldest_chk #(.DEPTH(DEPTH), .POS_W(POS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mrg_vld (mrg_vld),
  .mrg_rdy (mrg_rdy),
  .mrg_pos (mrg_pos),
  .iss_vld (iss_vld),
  .iss_rdy (iss_rdy),
  .rep_req (rep_req),
  .head_q  (head_q),
  .tail_q  (tail_q)
);

// File: tb/ntab_oldest_tb.sv
`timescale 1ns/1ps
module ntab_oldest_tb;
  localparam int DEPTH = 8, TAG_W = 6, DATA_W = 16, OP_W = 4, NB = 2;
  localparam int POS_W = $clog2(DEPTH) + 1;
  localparam int NPOS = 2 * DEPTH;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mrg_vld, mrg_rdy, mrg_a_rdy, mrg_b_rdy, iss_vld, iss_rdy, rep_req;
  logic [OP_W-1:0] mrg_op, iss_op;
  logic [TAG_W-1:0] mrg_dst, mrg_a_tag, mrg_b_tag, iss_dst;
  logic [DATA_W-1:0] mrg_a_val, mrg_b_val, iss_a, iss_b;
  logic [POS_W-1:0] mrg_pos, rep_pos;
  logic [NB-1:0] bc_vld;
  logic [NB*TAG_W-1:0] bc_tag;
  logic [NB*DATA_W-1:0] bc_val;

  ntab_oldest u_dut (.*);

  typedef struct {int pos; int op; int dst; bit r0; bit r1; int t0; int t1; int v0; int v1; bit iss;} ent_t;
  ent_t q[$];
  int mhead, mtail, total, bad, ex_idx;
  bit ex_vld, done;
  string cur_tag;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // bench-side wakeup of one source, lowest port wins
  task automatic wake(inout bit r, input int t, inout int v);
    if (!r) begin
      for (int p = 0; p < NB; p++) begin
        if (!r && bc_vld[p] && int'(bc_tag[p*TAG_W +: TAG_W]) == t) begin
          r = 1; v = int'(bc_val[p*DATA_W +: DATA_W]);
        end
      end
    end
  endtask

  task automatic compare();
    ex_vld = 0; ex_idx = 0;
    if (!rep_req) begin
      foreach (q[i]) if (!ex_vld && !q[i].iss && q[i].r0 && q[i].r1) begin ex_vld = 1; ex_idx = i; end
    end
    chk(mrg_rdy == (q.size() < DEPTH), {"R3/", cur_tag}, "mrg_rdy", int'(mrg_rdy), int'(q.size() < DEPTH));
    chk(int'(mrg_pos) == mtail, {"R2/", cur_tag}, "mrg_pos", int'(mrg_pos), mtail);
    chk(iss_vld == ex_vld, {"R4/", cur_tag}, "iss_vld", int'(iss_vld), int'(ex_vld));
    if (ex_vld && iss_vld) begin
      chk(int'(iss_op) == q[ex_idx].op, {"R4/", cur_tag}, "iss_op", int'(iss_op), q[ex_idx].op);
      chk(int'(iss_dst) == q[ex_idx].dst, {"R4/", cur_tag}, "iss_dst", int'(iss_dst), q[ex_idx].dst);
      chk(int'(iss_a) == q[ex_idx].v0, {"R6/", cur_tag}, "iss_a", int'(iss_a), q[ex_idx].v0);
      chk(int'(iss_b) == q[ex_idx].v1, {"R6/", cur_tag}, "iss_b", int'(iss_b), q[ex_idx].v1);
    end
  endtask

  task automatic update();
    bit pop0;
    int keep;
    ent_t e;
    pop0 = (q.size() > 0) && q[0].iss;
    if (ex_vld && iss_rdy) q[ex_idx].iss = 1;
    foreach (q[i]) begin
      wake(q[i].r0, q[i].t0, q[i].v0);
      wake(q[i].r1, q[i].t1, q[i].v1);
    end
    if (rep_req) begin
      keep = 0;
      foreach (q[i]) if (q[i].pos == int'(rep_pos)) keep = i + 1;
      while (q.size() > keep) void'(q.pop_back());
    end else if (mrg_vld && q.size() < DEPTH) begin
      e = '{pos: mtail, op: int'(mrg_op), dst: int'(mrg_dst), r0: mrg_a_rdy, r1: mrg_b_rdy,
            t0: int'(mrg_a_tag), t1: int'(mrg_b_tag), v0: int'(mrg_a_val), v1: int'(mrg_b_val), iss: 0};
      wake(e.r0, e.t0, e.v0);
      wake(e.r1, e.t1, e.v1);
      q.push_back(e);
    end
    if (pop0 && q.size() > 0) begin
      void'(q.pop_front());
      mhead = (mhead + 1) % NPOS;
    end
    mtail = (mhead + q.size()) % NPOS;
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    mrg_vld = 0; bc_vld = '0; iss_rdy = 1; rep_req = 0;
  endtask

  task automatic put(int op, int dst, bit ra, int ta, int va, bit rb, int tb, int vb);
    mrg_vld = 1; mrg_op = OP_W'(op); mrg_dst = TAG_W'(dst);
    mrg_a_rdy = ra; mrg_a_tag = TAG_W'(ta); mrg_a_val = DATA_W'(va);
    mrg_b_rdy = rb; mrg_b_tag = TAG_W'(tb); mrg_b_val = DATA_W'(vb);
  endtask

  task automatic bcast(int p, int t, int v);
    bc_vld[p] = 1;
    bc_tag[p*TAG_W +: TAG_W] = TAG_W'(t);
    bc_val[p*DATA_W +: DATA_W] = DATA_W'(v);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not end actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int ck;
    total = 0; bad = 0; done = 0; mhead = 0; mtail = 0; cur_tag = "R1";
    idle(); put(0, 0, 0, 0, 0, 0, 0, 0); mrg_vld = 0;
    bc_tag = '0; bc_val = '0; rep_pos = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(mrg_rdy == 1, "R1", "mrg_rdy after reset", int'(mrg_rdy), 1);
    chk(iss_vld == 0, "R1", "iss_vld after reset", int'(iss_vld), 0);
    chk(mrg_pos == 0, "R1", "mrg_pos after reset", int'(mrg_pos), 0);
    @(negedge clk);

    // oldest ready wins over older waiting entry
    cur_tag = "R4";
    put(1, 30, 0, 5, 0, 1, 0, 11); step();
    put(2, 31, 1, 0, 21, 1, 0, 22); step();
    put(3, 32, 1, 0, 31, 1, 0, 32); step();
    idle(); step();
    cur_tag = "R6";
    bcast(0, 5, 555); step();
    idle(); repeat (4) step();

    // hold with function unit busy
    cur_tag = "R5";
    iss_rdy = 0;
    put(4, 33, 1, 0, 41, 1, 0, 42); step();
    put(5, 34, 1, 0, 51, 1, 0, 52); step();
    mrg_vld = 0; repeat (3) step();
    iss_rdy = 1; repeat (4) step();

    // fill to full
    cur_tag = "R3";
    iss_rdy = 0;
    for (int k = 0; k < DEPTH + 2; k++) begin put(6, 40 + k, 0, 50 + k, 0, 1, 0, k); step(); end
    mrg_vld = 0;
    for (int k = 0; k < DEPTH; k++) bcast(k % NB, 50 + k, 900 + k);
    iss_rdy = 1; step();
    bc_vld = '0;
    for (int k = 0; k < DEPTH; k++) begin bcast(0, 50 + k, 900 + k); step(); end
    idle(); repeat (DEPTH + 4) step();

    // merge and broadcast race
    cur_tag = "R7";
    put(7, 1, 0, 9, 0, 0, 10, 0); bcast(0, 9, 1234); bcast(1, 10, 4321); step();
    idle(); repeat (3) step();

    // literal immune to matching broadcast
    cur_tag = "R8";
    put(8, 2, 1, 12, 77, 0, 13, 0); step();
    mrg_vld = 0; bcast(0, 12, 1); step();
    bc_vld = '0; bcast(1, 13, 5); step();
    idle(); repeat (3) step();

    // duplicate tags on both ports
    cur_tag = "R12";
    put(9, 3, 0, 20, 0, 1, 0, 3); step();
    mrg_vld = 0; bcast(0, 20, 111); bcast(1, 20, 222); step();
    idle(); repeat (3) step();

    // partial repair
    cur_tag = "R9";
    for (int k = 0; k < 4; k++) begin put(10, 4 + k, 0, 60 + k, 0, 1, 0, 0); step(); end
    idle();
    ck = q[1].pos;
    rep_req = 1; rep_pos = POS_W'(ck);
    put(11, 9, 1, 0, 1, 1, 0, 2); step();
    idle(); #1;
    chk(int'(mrg_pos) == (ck + 1) % NPOS, "R9", "mrg_pos after repair", int'(mrg_pos), (ck + 1) % NPOS);
    @(negedge clk);
    bcast(0, 60, 6); bcast(1, 61, 7); step();
    idle(); repeat (3) step();

    // repair outside window, plus issue suppression
    cur_tag = "R10";
    put(12, 5, 0, 62, 0, 1, 0, 0); step();
    put(12, 6, 1, 0, 8, 1, 0, 9); step();
    idle();
    rep_req = 1; rep_pos = POS_W'((mtail + 3) % NPOS);
    #1;
    chk(iss_vld == 0, "R11", "iss_vld in repair", int'(iss_vld), 0);
    @(negedge clk);
    idle(); #1;
    chk(int'(mrg_pos) == mhead, "R10", "mrg_pos after full flush", int'(mrg_pos), mhead);
    chk(iss_vld == 0, "R10", "iss_vld after full flush", int'(iss_vld), 0);
    mtail = int'(mrg_pos); q.delete();
    @(negedge clk);

    cur_tag = "R11";
    put(13, 7, 1, 0, 1, 1, 0, 2); step();
    rep_req = 1; rep_pos = POS_W'(q[0].pos); put(14, 8, 1, 0, 3, 1, 0, 4); step();
    idle(); repeat (3) step();

    // random traffic
    cur_tag = "rand";
    for (int c = 0; c < 4000; c++) begin
      idle();
      if ($urandom_range(99) < 60)
        put($urandom_range(15), $urandom_range(63), $urandom_range(2) == 0, $urandom_range(15),
            $urandom_range(65535), $urandom_range(2) == 0, $urandom_range(15), $urandom_range(65535));
      for (int p = 0; p < NB; p++)
        if ($urandom_range(99) < 40) bcast(p, $urandom_range(15), $urandom_range(65535));
      iss_rdy = ($urandom_range(99) < 75);
      if ($urandom_range(99) < 3) begin
        rep_req = 1;
        rep_pos = POS_W'((q.size() > 0 && $urandom_range(3) != 0) ?
                         q[$urandom_range(q.size() - 1)].pos : $urandom_range(NPOS - 1));
      end
      step();
    end
    idle(); repeat (20) step();
    finish_run();
  end
endmodule